// File: doc/BRIEF.md
# Byte-Instruction Two-Port Processor Core

This is a small 8-bit processor without a pipeline. It has four 8-bit general registers and sixteen operations, and every instruction is one byte long. Instructions are fetched through a read-only port. Loads and stores use a separate read/write port, so program code and data can sit in different memories. Both ports are expected to be synchronous memories whose read data appears one cycle after the address.

Each instruction has a fetch cycle, in which the program counter is on the instruction port, and an execute cycle, in which the returned byte is decoded and carried out. A load needs one further cycle to write the data-port result into its destination register. Wide constants are put together in register 0 four bits at a time. Control flow has four forms:
- a branch that skips forward only when a register holds zero;
- a relative jump forward;
- a relative jump backward;
- a jump through a register that saves the return address.

Top module: `byte_core`

## Requirements
- R1: Instruction bits [7:4] hold the opcode. Bits [3:2] hold register index a and bits [1:0] hold register index b, where index 0 to 3 is encoded 00 to 11. The byte is fetched from `imem_addr` = PC. A non-load instruction takes two cycles, fetch then execute, so a store that follows another store reaches the data port 2 cycles after it.
- R2: A synchronous reset clears the PC and all four registers to zero. While reset is asserted, `imem_addr` is 0 and `dmem_we` is 0.
- R3: Opcode 0010 sets a = ~b. Opcode 0011 sets a = a & b. Opcode 0100 sets a = a | b. Opcode 0101 sets a = a ^ b.
- R4: Opcode 0110 sets a = a + b modulo 256. Opcode 0111 sets a = 1 when a < b as unsigned numbers, and a = 0 otherwise.
- R5: Opcode 0000 shifts a left by b and opcode 0001 shifts a right (logical) by b. A shift amount of 8 or more gives 0.
- R6: Opcode 1000 loads a from data address b and takes one extra cycle, so a store, then a load, then a store puts the two stores 5 cycles apart. Opcode 1001 writes b to data address a, with `dmem_we` high only in that execute cycle.
- R7: Opcode 1010 writes the 4-bit immediate (bits [3:0]) into register 0 bits [3:0]. Opcode 1011 writes it into register 0 bits [7:4]. The other nibble of register 0 keeps its value.
- R8: Opcode 1100 sets PC to the value that b held before the instruction and writes the instruction's address + 1 into a. This also works when a and b are the same register.
- R9: Opcode 1101 takes register a from bits [3:2] and a 2-bit offset from bits [1:0]. If a is nonzero, PC becomes PC+1. If a is zero, PC becomes PC+1+offset.
- R10: Opcode 1110 sets PC to PC+1+imm4. Opcode 1111 sets PC to PC-1-imm4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction port address, equal to the PC |
| imem_rdata | input | 8 | Instruction byte, valid one cycle after its address |
| dmem_addr | output | 8 | Data port address for loads and stores |
| dmem_rdata | input | 8 | Load data, valid one cycle after its address |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store write strobe |

## Verification
Results can only be seen through stores, so each program stores every intermediate value to an address one higher than the previous store. Any misordered or extra store is therefore caught as a data or address mismatch.

Operand values are chosen to tell similar behaviours apart:
- 0x35 against 0xCA gives a different set-less-than result under signed and unsigned comparison.
- 0xFF + 1 shows that addition wraps.
- Shift amounts of 1, 0xC3 and 0xC8 separate a truncated shift amount from a true large shift.

Control flow is checked in several ways. Every jump and skipped branch is followed by filler stores that must never happen. The zero branch is tried with a nonzero register, with a zero register and offset 2, and with a zero register and offset 0. A countdown loop checks the backward jump and the exit taken by the branch.

// File: rtl/bc_pkg.sv
package bc_pkg;

    localparam int DW   = 8;              // datapath and address width
    localparam int NREG = 4;              // general registers
    localparam int RW   = $clog2(NREG);   // register index width
    localparam int OPW  = 4;              // opcode width
    localparam int IMW  = DW - OPW;       // operand field / wide immediate width
    localparam int SIW  = IMW - RW;       // short branch offset width
    localparam int HALF = DW / 2;         // nibble written by constant builds

    typedef logic [DW-1:0]  word_t;
    typedef logic [RW-1:0]  ridx_t;
    typedef logic [IMW-1:0] imm_t;
    typedef logic [SIW-1:0] simm_t;

    typedef enum logic [OPW-1:0] {
        OP_SHL  = 4'h0,
        OP_SHR  = 4'h1,
        OP_INV  = 4'h2,
        OP_AND  = 4'h3,
        OP_IOR  = 4'h4,
        OP_XOR  = 4'h5,
        OP_ADD  = 4'h6,
        OP_LTU  = 4'h7,
        OP_LD   = 4'h8,
        OP_ST   = 4'h9,
        OP_LDLO = 4'hA,
        OP_LDHI = 4'hB,
        OP_JREG = 4'hC,
        OP_BRZ  = 4'hD,
        OP_JFWD = 4'hE,
        OP_JBWD = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_LOAD  = 2'd2
    } phase_e;

    typedef struct packed {
        op_e   op;
        ridx_t ra;
        ridx_t rb;
        imm_t  imm;
        simm_t simm;
    } dec_t;

    typedef struct packed {
        logic             we;
        logic [1:0]       mask;   // [1] upper nibble, [0] lower nibble
        ridx_t            addr;
        word_t            data;
    } wb_t;

    function automatic dec_t decode(input word_t w);
        dec_t d;
        d.op   = op_e'(w[DW-1 -: OPW]);
        d.ra   = w[IMW-1 -: RW];
        d.rb   = w[RW-1:0];
        d.imm  = w[IMW-1:0];
        d.simm = w[SIW-1:0];
        return d;
    endfunction

    function automatic logic is_alu(input op_e op);
        return op[OPW-1] == 1'b0;
    endfunction

endpackage

// File: rtl/bc_regfile.sv
module bc_regfile
    import bc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_a,
    input  ridx_t rd_b,
    output word_t val_a,
    output word_t val_b,
    input  wb_t   wb
);

    word_t regs [NREG];

    assign val_a = regs[rd_a];
    assign val_b = regs[rd_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (wb.we) begin
            if (wb.mask[0]) regs[wb.addr][HALF-1:0]  <= wb.data[HALF-1:0];
            if (wb.mask[1]) regs[wb.addr][DW-1:HALF] <= wb.data[DW-1:HALF];
        end
    end

    AST_LO_BUILD_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (wb.we && wb.mask == 2'b01 && wb.addr == '0)
        |=> regs[0][DW-1:HALF] == $past(regs[0][DW-1:HALF])); // R7

    AST_HI_BUILD_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (wb.we && wb.mask == 2'b10 && wb.addr == '0)
        |=> regs[0][HALF-1:0] == $past(regs[0][HALF-1:0])); // R7

endmodule

// File: rtl/bc_alu.sv
module bc_alu
    import bc_pkg::*;
(
    input  op_e   op,
    input  word_t a,
    input  word_t b,
    output word_t y
);

    localparam int    SHW    = $clog2(DW);
    localparam word_t SH_LIM = word_t'(DW);

    logic  flush;
    word_t shl_v;
    word_t shr_v;

    assign flush = (b >= SH_LIM);
    assign shl_v = a << b[SHW-1:0];
    assign shr_v = a >> b[SHW-1:0];

    always_comb begin
        case (op)
            OP_SHL:  y = flush ? '0 : shl_v;
            OP_SHR:  y = flush ? '0 : shr_v;
            OP_INV:  y = ~b;
            OP_AND:  y = a & b;
            OP_IOR:  y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_LTU:  y = word_t'(a < b);
            default: y = '0;
        endcase
    end

    always_comb begin
        AST_LTU_IS_BOOL: assert (op != OP_LTU || y <= word_t'(1)); // R4
        AST_WIDE_SHIFT_ZERO: assert (!((op == OP_SHL || op == OP_SHR) && flush) || y == '0); // R5
    end

endmodule

// File: rtl/bc_nextpc.sv
module bc_nextpc
    import bc_pkg::*;
(
    input  op_e   op,
    input  word_t pc,
    input  word_t val_a,
    input  word_t val_b,
    input  imm_t  imm,
    input  simm_t simm,
    output word_t npc
);

    word_t seq;

    assign seq = pc + word_t'(1);

    always_comb begin
        case (op)
            OP_JREG: npc = val_b;
            OP_BRZ:  npc = (val_a == '0) ? seq + word_t'(simm) : seq;
            OP_JFWD: npc = seq + word_t'(imm);
            OP_JBWD: npc = pc - word_t'(1) - word_t'(imm);
            default: npc = seq;
        endcase
    end

endmodule

// File: rtl/byte_core.sv
module byte_core
    import bc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] imem_addr,
    input  logic [DW-1:0] imem_rdata,
    output logic [DW-1:0] dmem_addr,
    input  logic [DW-1:0] dmem_rdata,
    output logic [DW-1:0] dmem_wdata,
    output logic          dmem_we
);

    phase_e state;
    word_t  pc;
    ridx_t  ld_dst;
    dec_t   dec;
    op_e    cur_op;
    logic   in_exec;
    word_t  val_a;
    word_t  val_b;
    word_t  alu_y;
    word_t  npc;
    wb_t    wb;

    assign dec     = decode(imem_rdata);
    assign cur_op  = dec.op;
    assign in_exec = (state == ST_EXEC);

    bc_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .rd_a  (dec.ra),
        .rd_b  (dec.rb),
        .val_a (val_a),
        .val_b (val_b),
        .wb    (wb)
    );

    bc_alu u_alu (
        .op (cur_op),
        .a  (val_a),
        .b  (val_b),
        .y  (alu_y)
    );

    bc_nextpc u_npc (
        .op    (cur_op),
        .pc    (pc),
        .val_a (val_a),
        .val_b (val_b),
        .imm   (dec.imm),
        .simm  (dec.simm),
        .npc   (npc)
    );

    // Register write-back selection
    always_comb begin
        wb.we   = 1'b0;
        wb.mask = 2'b11;
        wb.addr = dec.ra;
        wb.data = alu_y;
        if (state == ST_LOAD) begin
            wb.we   = 1'b1;
            wb.addr = ld_dst;
            wb.data = dmem_rdata;
        end else if (in_exec) begin
            case (cur_op)
                OP_LDLO: begin
                    wb.we   = 1'b1;
                    wb.addr = '0;
                    wb.mask = 2'b01;
                    wb.data = {dec.imm, dec.imm};
                end
                OP_LDHI: begin
                    wb.we   = 1'b1;
                    wb.addr = '0;
                    wb.mask = 2'b10;
                    wb.data = {dec.imm, dec.imm};
                end
                OP_JREG: begin
                    wb.we   = 1'b1;
                    wb.data = pc + word_t'(1);
                end
                default: wb.we = is_alu(cur_op);
            endcase
        end
    end

    // Fetch / execute / load-return sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FETCH;
            pc     <= '0;
            ld_dst <= '0;
        end else begin
            case (state)
                ST_FETCH: state <= ST_EXEC;
                ST_EXEC: begin
                    pc     <= npc;
                    ld_dst <= dec.ra;
                    state  <= (cur_op == OP_LD) ? ST_LOAD : ST_FETCH;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

    assign imem_addr  = pc;
    assign dmem_we    = in_exec && (cur_op == OP_ST);
    assign dmem_addr  = !in_exec ? '0 : ((cur_op == OP_ST) ? val_a : val_b);
    assign dmem_wdata = val_b;

    AST_SINGLE_EXEC: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cur_op != OP_LD) |=> state == ST_FETCH); // R1

    AST_PC_HELD_OUTSIDE_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXEC) |=> $stable(pc)); // R1

    AST_LOAD_EXTRA_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cur_op == OP_LD) |=> state == ST_LOAD); // R6

    AST_STROBE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> state == ST_EXEC); // R6

    AST_FWD_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cur_op == OP_JFWD)
        |=> pc == $past(pc) + word_t'(1) + word_t'($past(imem_rdata[IMW-1:0]))); // R10

endmodule

// File: tb/byte_core_tb.sv
module byte_core_tb;
    import bc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
    logic dmem_we;

    logic [7:0] imem [0:255];
    logic [7:0] dmem [0:255];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wp;
    int nxt;
    bit done = 1'b0;

    logic [7:0] exp_a [$];
    logic [7:0] exp_d [$];
    string      exp_t [$];
    int         st_cyc [$];

    always #5 clk = ~clk;

    byte_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we)
    );

    // synchronous memories, one-cycle read
    always @(posedge clk) begin
        cyc++;
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    function automatic logic [7:0] rt(input op_e op, input int a, input int b);
        return {op, 2'(a), 2'(b)};
    endfunction

    function automatic logic [7:0] it(input op_e op, input int imm);
        return {op, 4'(imm)};
    endfunction

    task automatic put(input logic [7:0] b);
        imem[wp] = b;
        wp++;
    endtask

    task automatic expect_st(input int a, input int d, input string tag);
        exp_a.push_back(8'(a));
        exp_d.push_back(8'(d));
        exp_t.push_back(tag);
    endtask

    // store register src to address r1, then r1 += r3 (r3 holds 1)
    task automatic emit_store(input int src, input int d, input string tag);
        put(rt(OP_ST, 1, src));
        put(rt(OP_ADD, 1, 3));
        expect_st(nxt, d, tag);
        nxt++;
    endtask

    task automatic filler();
        put(rt(OP_ST, 1, 1));
    endtask

    task automatic halt();
        put(it(OP_JFWD, 0));
        put(it(OP_JBWD, 0));
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: pops one expected store per observed store
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            st_cyc.push_back(cyc);
            checks++;
            if (exp_a.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected store actual %0h:%0h expected none",
                         dmem_addr, dmem_wdata);
            end else begin
                logic [7:0] ea;
                logic [7:0] ed;
                string      et;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                et = exp_t.pop_front();
                if (dmem_addr !== ea || dmem_wdata !== ed) begin
                    errors++;
                    $display("FAIL %s store actual %0h:%0h expected %0h:%0h",
                             et, dmem_addr, dmem_wdata, ea, ed);
                end
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 8'h00;
            dmem[i] = 8'h00;
        end
        exp_a.delete();
        exp_d.delete();
        exp_t.delete();
        st_cyc.delete();
        wp  = 0;
        nxt = 8'h80;
    endtask

    task automatic start_prog();
        repeat (3) @(negedge clk);
        chk(imem_addr == 8'h00, "R2 pc in reset", imem_addr, 0);
        chk(dmem_we == 1'b0, "R2 strobe in reset", dmem_we, 0);
        rst = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 4000 && exp_a.size() != 0; k++) @(negedge clk);
        repeat (30) @(negedge clk);
        while (exp_a.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s missing store actual none expected %0h:%0h",
                     exp_t[0], exp_a[0], exp_d[0]);
            void'(exp_a.pop_front());
            void'(exp_d.pop_front());
            void'(exp_t.pop_front());
        end
        @(negedge clk);
        rst = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        wrap_up();
    end

    initial begin
        int j1;
        int j2;
        int lp;

        // ---------------- program 1: arithmetic, logic, constants
        clear_mem();
        put(rt(OP_ST, 1, 2)); expect_st(0, 0, "R2 regs cleared");
        put(rt(OP_ST, 1, 2)); expect_st(0, 0, "R2 regs cleared");
        put(it(OP_LDLO, 1)); put(rt(OP_ADD, 3, 0));              // r3 = 1
        put(it(OP_LDLO, 0)); put(it(OP_LDHI, 8)); put(rt(OP_ADD, 1, 0)); // r1 = 80
        put(it(OP_LDLO, 10)); put(it(OP_LDHI, 3)); put(rt(OP_ADD, 2, 0)); // r2 = 3A
        put(it(OP_LDLO, 5)); put(it(OP_LDHI, 12));               // r0 = C5
        put(rt(OP_ADD, 2, 0)); emit_store(2, 8'hFF, "R4 add");
        put(rt(OP_AND, 2, 0)); emit_store(2, 8'hC5, "R3 and");
        put(it(OP_LDLO, 10));                                    // r0 = CA
        put(rt(OP_XOR, 2, 0)); emit_store(2, 8'h0F, "R3 xor");
        put(rt(OP_IOR, 2, 0)); emit_store(2, 8'hCF, "R3 or");
        put(rt(OP_INV, 2, 0)); emit_store(2, 8'h35, "R3 not");
        put(rt(OP_LTU, 2, 0)); emit_store(2, 8'h01, "R4 slt unsigned true");
        put(rt(OP_ADD, 2, 0)); put(rt(OP_LTU, 2, 0));
        emit_store(2, 8'h00, "R4 slt false");
        put(rt(OP_ADD, 2, 0)); put(rt(OP_SHL, 2, 3));
        emit_store(2, 8'h94, "R5 shift left 1");
        put(rt(OP_SHR, 2, 3)); emit_store(2, 8'h4A, "R5 shift right 1");
        put(it(OP_LDLO, 3));                                     // r0 = C3
        put(rt(OP_SHL, 2, 0)); emit_store(2, 8'h00, "R5 wide left shift");
        put(rt(OP_ADD, 2, 0)); put(it(OP_LDLO, 8));              // r2 = C3, r0 = C8
        put(rt(OP_SHR, 2, 0)); emit_store(2, 8'h00, "R5 wide right shift");
        emit_store(0, 8'hC8, "R7 low nibble build keeps high");
        put(it(OP_LDHI, 2)); emit_store(0, 8'h28, "R7 high nibble build keeps low");
        put(it(OP_LDLO, 15)); put(it(OP_LDHI, 15));              // r0 = FF
        put(rt(OP_ADD, 2, 0)); put(rt(OP_ADD, 2, 3));
        emit_store(2, 8'h00, "R4 add wraps");
        halt();
        start_prog();
        drain();
        if (st_cyc.size() >= 2)
            chk(st_cyc[1] - st_cyc[0] == 2, "R1 store-store spacing", st_cyc[1] - st_cyc[0], 2);
        else
            chk(1'b0, "R1 store-store spacing", st_cyc.size(), 2);

        // ---------------- program 2: memory and control flow
        clear_mem();
        nxt = 8'h90;
        dmem[8'h00] = 8'h5A;
        dmem[8'h40] = 8'h77;
        put(rt(OP_ST, 1, 2)); expect_st(0, 0, "R6 store");
        put(rt(OP_LD, 2, 0));
        put(rt(OP_ST, 1, 2)); expect_st(0, 0, "R6 load sees prior store");
        put(it(OP_LDLO, 1)); put(rt(OP_ADD, 3, 0));              // r3 = 1
        put(it(OP_LDLO, 0)); put(it(OP_LDHI, 9)); put(rt(OP_ADD, 1, 0)); // r1 = 90
        put(it(OP_LDHI, 4));                                     // r0 = 40
        put(rt(OP_LD, 2, 0)); emit_store(2, 8'h77, "R6 load");
        put(rt(OP_LD, 0, 0)); emit_store(0, 8'h77, "R6 load into address reg");
        put(it(OP_LDLO, 0)); put(it(OP_LDHI, 6));                // r0 = 60
        j1 = wp;
        put(rt(OP_JREG, 2, 0)); filler();
        wp = 8'h60;
        emit_store(2, j1 + 1, "R8 jump link");
        put(it(OP_LDLO, 0)); put(it(OP_LDHI, 7));                // r0 = 70
        j2 = wp;
        put(rt(OP_JREG, 0, 0)); filler();
        wp = 8'h70;
        emit_store(0, j2 + 1, "R8 jump link same reg");
        put(rt(OP_BRZ, 3, 2)); emit_store(3, 8'h01, "R9 nonzero falls through");
        put(rt(OP_XOR, 2, 2));
        put(rt(OP_BRZ, 2, 2)); filler(); filler();
        emit_store(2, 8'h00, "R9 zero skips two");
        put(rt(OP_BRZ, 2, 0)); emit_store(2, 8'h00, "R9 zero offset 0");
        put(it(OP_JFWD, 3)); filler(); filler(); filler();
        emit_store(3, 8'h01, "R10 forward jump");
        put(it(OP_LDLO, 13)); put(it(OP_LDHI, 15));              // r0 = FD
        put(rt(OP_XOR, 2, 2));
        lp = wp;
        put(rt(OP_ADD, 2, 3));
        put(rt(OP_ADD, 0, 3));
        put(rt(OP_BRZ, 0, 1));
        put(it(OP_JBWD, wp - 1 - lp));
        emit_store(2, 8'h03, "R10 backward jump loop");
        halt();
        start_prog();
        drain();
        if (st_cyc.size() >= 2)
            chk(st_cyc[1] - st_cyc[0] == 5, "R6 load extra cycle", st_cyc[1] - st_cyc[0], 5);
        else
            chk(1'b0, "R6 load extra cycle", st_cyc.size(), 5);

        wrap_up();
    end

endmodule